// File: doc/BRIEF.md
# Interlocked Memory Read Link

This block moves one memory read at a time across a single shared address/data bus between two parties that share no clock. A requester, which stands for an I/O device, puts an address on the bus and collects the returned word. A responder, which stands for a memory, latches that address, looks up a word in an internal array model and sends the word back on the same bus.

Three control lines carry the exchange: a read request, an acknowledge and a data-ready strobe. Each step waits for the peer to change a level, and never for a fixed number of cycles. A full read therefore takes eight edges on the control lines. Each side passes the incoming control lines through a synchronizer chain before its state machine acts on them. The shared bus is modelled with one drive-enable per side rather than tri-state wires.

The requester's user asks for a read with a one-cycle `start` pulse and an address. It then waits for `done`, which comes with the fetched word on `rd_data`. The responder inserts a set number of its own clock cycles of memory latency before it returns data.

Top module: `rdlink_top`

## Requirements
- R1: While either reset is held, `read_req`, `ack`, `data_rdy`, both drive enables, `done` and `busy` are 0.
- R2: A `start` accepted in idle makes the requester drive `start_addr` on the bus and raise `read_req`. The requester drops `read_req` and its drive enable together, and only after it has seen `ack` high.
- R3: The responder raises `ack` after it sees `read_req` high. It drops that `ack` only after it sees `read_req` low.
- R4: The responder raises `data_rdy` together with its drive enable and the fetched word. It does so only after it has seen `ack` low, and at least LATENCY responder-clock cycles after it raised `ack`.
- R5: After the requester sees `data_rdy` high, it captures the bus and raises `ack`. The responder then drops `data_rdy` and its drive enable. The requester drops `ack` only after it sees `data_rdy` low, which closes the transaction. Across one read, the control lines change in exactly this order: req↑ ack↑ req↓ ack↓ rdy↑ ack↑ rdy↓ ack↓.
- R6: The two drive enables are never both high.
- R7: `done` is high for exactly one requester-clock cycle, at the final `ack` drop. `rd_data` then holds the word for address a, which is (a×261 XOR 0x5A3CA5C3) truncated to DATA_W bits.
- R8: Only the low log2(DEPTH) bits of the address select the word; higher address bits have no effect on the returned data.
- R9: `busy` is high from the cycle after an accepted `start` until the requester has seen the final `ack` low. A `start` while `busy` is high is ignored: it starts no transaction and does not change the result of the transaction in flight.
- R10: When neither side drives, `bus_data` reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Requester clock |
| rst_a_n | input | 1 | Requester reset, active low, asynchronous |
| start | input | 1 | One-cycle read request from the user |
| start_addr | input | DATA_W | Address to read |
| busy | output | 1 | Transaction in flight on the requester side |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Word returned by the last read |
| clk_b | input | 1 | Responder clock |
| rst_b_n | input | 1 | Responder reset, active low, asynchronous |
| read_req | output | 1 | Read request line on the bus |
| ack | output | 1 | Acknowledge line, driven by either side |
| data_rdy | output | 1 | Data-ready line on the bus |
| req_drive_en | output | 1 | Requester is driving the bus |
| rsp_drive_en | output | 1 | Responder is driving the bus |
| bus_data | output | DATA_W | Resolved shared address/data bus |

## Verification
The two clocks in the bench run at unrelated periods with an offset phase. A design that acted on a stale, still-synchronizing acknowledge would skip a handshake step, and the edge-order monitor would catch this as an out-of-sequence change. The bench reads address zero, the top entry, and addresses with high bits set. A design that used the full address word would return the wrong array entry. A second `start` pulse lands in the middle of a read. A requester that took it would issue a second request, produce two `done` pulses or return the second address's word. The bench also times the gap from `ack` to `data_rdy` against the latency setting and watches both drive enables at every edge. This would expose a responder that answers early or that grabs the bus while the address is still on it.

// File: rtl/rdlink_pkg.sv
package rdlink_pkg;

   typedef enum logic [2:0] {
      RQ_IDLE,
      RQ_ADDR,
      RQ_ACKLOW,
      RQ_WAITDR,
      RQ_DRLOW,
      RQ_FIN
   } rq_state_t;

   typedef enum logic [2:0] {
      RS_IDLE,
      RS_GOT,
      RS_CLR,
      RS_FETCH,
      RS_SERVE,
      RS_END
   } rs_state_t;

   // Constants of the array model's fill pattern
   localparam logic [31:0] FILL_MUL = 32'd261;
   localparam logic [31:0] FILL_XOR = 32'h5A3C_A5C3;

endpackage

// File: rtl/rdlink_sync.sv
module rdlink_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   initial begin
      if (STAGES < 1) $fatal(1, "rdlink_sync: STAGES must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rdlink_requester.sv
module rdlink_requester
   import rdlink_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] start_addr,
   input  logic              ack_line,
   input  logic              rdy_line,
   input  logic [DATA_W-1:0] bus_in,
   output logic              req_o,
   output logic              ack_o,
   output logic              drive_o,
   output logic [DATA_W-1:0] drive_val,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data
);

   rq_state_t st;
   logic      ack_s;
   logic      rdy_s;

   rdlink_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
      .clk(clk), .rst_n(rst_n), .d(ack_line), .q(ack_s)
   );

   rdlink_sync #(.STAGES(SYNC_STAGES)) u_sync_rdy (
      .clk(clk), .rst_n(rst_n), .d(rdy_line), .q(rdy_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RQ_IDLE;
         req_o     <= 1'b0;
         ack_o     <= 1'b0;
         drive_o   <= 1'b0;
         drive_val <= '0;
         done      <= 1'b0;
         rd_data   <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            RQ_IDLE: begin
               if (start) begin
                  drive_val <= start_addr;
                  drive_o   <= 1'b1;
                  req_o     <= 1'b1;
                  st        <= RQ_ADDR;
               end
            end
            RQ_ADDR: begin
               if (ack_s) begin
                  req_o   <= 1'b0;
                  drive_o <= 1'b0;
                  st      <= RQ_ACKLOW;
               end
            end
            RQ_ACKLOW: begin
               if (!ack_s) st <= RQ_WAITDR;
            end
            RQ_WAITDR: begin
               if (rdy_s) begin
                  rd_data <= bus_in;
                  ack_o   <= 1'b1;
                  st      <= RQ_DRLOW;
               end
            end
            RQ_DRLOW: begin
               if (!rdy_s) begin
                  ack_o <= 1'b0;
                  done  <= 1'b1;
                  st    <= RQ_FIN;
               end
            end
            RQ_FIN: begin
               if (!ack_s) st <= RQ_IDLE;
            end
            default: st <= RQ_IDLE;
         endcase
      end
   end

   assign busy = (st != RQ_IDLE);

endmodule

// File: rtl/rdlink_responder.sv
module rdlink_responder
   import rdlink_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 16,
   parameter int LATENCY     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_line,
   input  logic              ack_line,
   input  logic [DATA_W-1:0] bus_in,
   output logic              ack_o,
   output logic              rdy_o,
   output logic              drive_o,
   output logic [DATA_W-1:0] drive_val
);

   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W  = (LATENCY > 1) ? $clog2(LATENCY) : 1;

   function automatic logic [DATA_W-1:0] fill_word(input int idx);
      logic [31:0] raw;
      raw = (32'(idx) * FILL_MUL) ^ FILL_XOR;
      return DATA_W'(raw);
   endfunction

   rs_state_t         st;
   logic              req_s;
   logic              ack_s;
   logic [ADDR_W-1:0] addr_q;
   logic              fetch_done;
   logic [DATA_W-1:0] store [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_store
         assign store[g] = fill_word(g);
      end
   endgenerate

   rdlink_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
      .clk(clk), .rst_n(rst_n), .d(req_line), .q(req_s)
   );

   rdlink_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
      .clk(clk), .rst_n(rst_n), .d(ack_line), .q(ack_s)
   );

   generate
      if (LATENCY <= 1) begin : g_fast
         assign fetch_done = 1'b1;
      end else begin : g_wait
         logic [CNT_W-1:0] wait_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              wait_cnt <= '0;
            else if (st == RS_FETCH) wait_cnt <= wait_cnt + 1'b1;
            else                     wait_cnt <= '0;
         end
         assign fetch_done = (wait_cnt == CNT_W'(LATENCY - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RS_IDLE;
         ack_o     <= 1'b0;
         rdy_o     <= 1'b0;
         drive_o   <= 1'b0;
         drive_val <= '0;
         addr_q    <= '0;
      end else begin
         case (st)
            RS_IDLE: begin
               if (req_s) begin
                  addr_q <= bus_in[ADDR_W-1:0];
                  ack_o  <= 1'b1;
                  st     <= RS_GOT;
               end
            end
            RS_GOT: begin
               if (!req_s) begin
                  ack_o <= 1'b0;
                  st    <= RS_CLR;
               end
            end
            RS_CLR: begin
               if (!ack_s) st <= RS_FETCH;
            end
            RS_FETCH: begin
               if (fetch_done) begin
                  drive_val <= store[addr_q];
                  drive_o   <= 1'b1;
                  rdy_o     <= 1'b1;
                  st        <= RS_SERVE;
               end
            end
            RS_SERVE: begin
               if (ack_s) begin
                  drive_o <= 1'b0;
                  rdy_o   <= 1'b0;
                  st      <= RS_END;
               end
            end
            RS_END: begin
               if (!ack_s) st <= RS_IDLE;
            end
            default: st <= RS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rdlink_top.sv
module rdlink_top #(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 16,
   parameter int LATENCY     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_a,
   input  logic              rst_a_n,
   input  logic              start,
   input  logic [DATA_W-1:0] start_addr,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   input  logic              clk_b,
   input  logic              rst_b_n,
   output logic              read_req,
   output logic              ack,
   output logic              data_rdy,
   output logic              req_drive_en,
   output logic              rsp_drive_en,
   output logic [DATA_W-1:0] bus_data
);

   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   initial begin
      if (DEPTH < 2)         $fatal(1, "rdlink_top: DEPTH must be at least 2");
      if (ADDR_W > DATA_W)   $fatal(1, "rdlink_top: address does not fit the bus");
      if (LATENCY < 0)       $fatal(1, "rdlink_top: LATENCY must not be negative");
      if (SYNC_STAGES < 2)   $fatal(1, "rdlink_top: SYNC_STAGES must be at least 2");
   end

   logic              ack_from_req;
   logic              ack_from_rsp;
   logic [DATA_W-1:0] req_val;
   logic [DATA_W-1:0] rsp_val;

   // Acknowledge is a wired line that either party may pull high
   assign ack = ack_from_req | ack_from_rsp;

   // Bus resolution from the two drive enables
   assign bus_data = req_drive_en ? req_val :
                     rsp_drive_en ? rsp_val : '0;

   rdlink_requester #(
      .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_req (
      .clk(clk_a), .rst_n(rst_a_n),
      .start(start), .start_addr(start_addr),
      .ack_line(ack), .rdy_line(data_rdy), .bus_in(bus_data),
      .req_o(read_req), .ack_o(ack_from_req),
      .drive_o(req_drive_en), .drive_val(req_val),
      .busy(busy), .done(done), .rd_data(rd_data)
   );

   rdlink_responder #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .LATENCY(LATENCY), .SYNC_STAGES(SYNC_STAGES)
   ) u_rsp (
      .clk(clk_b), .rst_n(rst_b_n),
      .req_line(read_req), .ack_line(ack), .bus_in(bus_data),
      .ack_o(ack_from_rsp), .rdy_o(data_rdy),
      .drive_o(rsp_drive_en), .drive_val(rsp_val)
   );

endmodule

// File: rtl/rdlink_chk.sv
module rdlink_chk (
   input logic clk_a,
   input logic rst_a_n,
   input logic clk_b,
   input logic rst_b_n,
   input logic read_req,
   input logic ack,
   input logic data_rdy,
   input logic req_drive_en,
   input logic rsp_drive_en,
   input logic done
);

   // R6
   no_dual_drive_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n || !rst_b_n)
      !(req_drive_en && rsp_drive_en));

   // R6
   no_dual_drive_b_chk: assert property (@(posedge clk_b) disable iff (!rst_a_n || !rst_b_n)
      !(req_drive_en && rsp_drive_en));

   // R2
   req_drop_after_ack_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n || !rst_b_n)
      $fell(read_req) |-> (ack && !req_drive_en));

   // R3
   ack_drop_after_req_chk: assert property (@(posedge clk_b) disable iff (!rst_a_n || !rst_b_n)
      $fell(ack) |-> !read_req);

   // R4
   rdy_rise_chk: assert property (@(posedge clk_b) disable iff (!rst_a_n || !rst_b_n)
      $rose(data_rdy) |-> (!read_req && !ack && rsp_drive_en));

   // R5
   rdy_fall_chk: assert property (@(posedge clk_b) disable iff (!rst_a_n || !rst_b_n)
      $fell(data_rdy) |-> ack);

   // R7
   done_pulse_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n || !rst_b_n)
      done |=> !done);

   // R7
   done_after_rdy_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n || !rst_b_n)
      done |-> !data_rdy);

   // R9
   clean_start_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n || !rst_b_n)
      $rose(read_req) |-> (!ack && !data_rdy));

endmodule

bind rdlink_top rdlink_chk u_chk (
   .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n),
   .read_req(read_req), .ack(ack), .data_rdy(data_rdy),
   .req_drive_en(req_drive_en), .rsp_drive_en(rsp_drive_en), .done(done)
);

// File: tb/sim_rdlink_top.sv
`timescale 1ns/1ps
module sim_rdlink_top;

   localparam int DATA_W = 16;
   localparam int DEPTH  = 16;
   localparam int LAT    = 3;
   localparam int TB_PER = 11;

   logic              clk_a = 1'b0;
   logic              clk_b = 1'b0;
   logic              rst_a_n = 1'b0;
   logic              rst_b_n = 1'b0;
   logic              start = 1'b0;
   logic [DATA_W-1:0] start_addr = '0;
   logic              busy, done;
   logic [DATA_W-1:0] rd_data;
   logic              read_req, ack, data_rdy;
   logic              req_drive_en, rsp_drive_en;
   logic [DATA_W-1:0] bus_data;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #4 clk_a = ~clk_a;
   initial begin
      #1;
      forever #(TB_PER/2.0) clk_b = ~clk_b;
   end

   rdlink_top #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LATENCY(LAT), .SYNC_STAGES(2)) u0 (
      .clk_a(clk_a), .rst_a_n(rst_a_n), .start(start), .start_addr(start_addr),
      .busy(busy), .done(done), .rd_data(rd_data),
      .clk_b(clk_b), .rst_b_n(rst_b_n),
      .read_req(read_req), .ack(ack), .data_rdy(data_rdy),
      .req_drive_en(req_drive_en), .rsp_drive_en(rsp_drive_en), .bus_data(bus_data)
   );

   function automatic logic [DATA_W-1:0] exp_word(input logic [DATA_W-1:0] a);
      logic [31:0] raw;
      raw = (32'(a % DEPTH) * 32'd261) ^ 32'h5A3C_A5C3;
      return raw[DATA_W-1:0];
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Edge-order monitor for one read: req+ ack+ req- ack- rdy+ ack+ rdy- ack-
   int                bad_r2 = 0, bad_r3 = 0, bad_r4 = 0, bad_r5 = 0, bad_r6 = 0;
   int                step = 0;
   logic [DATA_W-1:0] cur_addr = '0;
   realtime           t_ack = 0;
   logic              p_rr = 1'b0, p_ack = 1'b0, p_dr = 1'b0;

   always @(read_req or ack or data_rdy) begin
      int kind, nval, nchg;
      int exp_kind[8];
      int exp_val[8];
      #1;
      exp_kind = '{0, 1, 0, 1, 2, 1, 2, 1};
      exp_val  = '{1, 1, 0, 0, 1, 1, 0, 0};
      nchg = 0; kind = 0; nval = 0;
      if (read_req !== p_rr) begin nchg++; kind = 0; nval = int'(read_req); end
      if (ack !== p_ack)     begin nchg++; kind = 1; nval = int'(ack); end
      if (data_rdy !== p_dr) begin nchg++; kind = 2; nval = int'(data_rdy); end
      p_rr = read_req; p_ack = ack; p_dr = data_rdy;
      if (nchg == 1 && rst_a_n && rst_b_n) begin
         if (kind == exp_kind[step] && nval == exp_val[step]) begin
            case (step)
               0: if (!(req_drive_en && bus_data == cur_addr)) bad_r2++;
               1: t_ack = $realtime;
               2: if (req_drive_en) bad_r2++;
               4: begin
                     if (($realtime - t_ack) < LAT * TB_PER) bad_r4++;
                     if (!(rsp_drive_en && bus_data == exp_word(cur_addr))) bad_r4++;
                  end
               6: if (rsp_drive_en) bad_r5++;
               default: ;
            endcase
            step = (step + 1) % 8;
         end else begin
            if (step == 0 || step == 2) bad_r2++;
            else if (step == 1 || step == 3) bad_r3++;
            else if (step == 4) bad_r4++;
            else bad_r5++;
         end
      end else if (nchg > 1) begin
         bad_r5++;
      end
   end

   always @(negedge clk_a or negedge clk_b) begin
      if (req_drive_en && rsp_drive_en) bad_r6++;
   end

   always @(posedge clk_a) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wait_done(output int n);
      n = 0;
      while (!done && n < 3000) begin
         @(negedge clk_a);
         n++;
      end
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 3000) begin
         @(negedge clk_a);
         n++;
      end
   endtask

   task automatic do_read(input logic [DATA_W-1:0] a, input string tag);
      int n;
      cur_addr = a;
      @(negedge clk_a);
      start = 1'b1; start_addr = a;
      @(negedge clk_a);
      start = 1'b0; start_addr = '0;
      wait_done(n);
      chk(done === 1'b1, {tag, " R7 done seen"}, 32'(done), 1);
      chk(rd_data === exp_word(a), {tag, " R7 data"}, 32'(rd_data), 32'(exp_word(a)));
      @(negedge clk_a);
      chk(done === 1'b0, {tag, " R7 done one cycle"}, 32'(done), 0);
      wait_idle();
      repeat (4) @(negedge clk_b);
      chk(step == 0, {tag, " R5 sequence complete"}, 32'(step), 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk_a);
      chk(!read_req && !ack && !data_rdy, "R1 control lines", {29'd0, read_req, ack, data_rdy}, 0);
      chk(!req_drive_en && !rsp_drive_en, "R1 drive enables", {30'd0, req_drive_en, rsp_drive_en}, 0);
      chk(!done && !busy, "R1 done/busy", {30'd0, done, busy}, 0);
      rst_a_n = 1'b1;
      rst_b_n = 1'b1;
      repeat (3) @(negedge clk_a);
   endtask

   task automatic t_basic();
      do_read(16'd0, "basic a0");
      do_read(16'd5, "basic a5");
      do_read(16'(DEPTH - 1), "basic top");
      do_read(16'd10, "basic a10");
   endtask

   task automatic t_wrap();
      do_read(16'h1235, "R8 high bits");
      do_read(16'hFFF0, "R8 high bits zero index");
   endtask

   task automatic t_busy();
      int dones = 0;
      int n = 0;
      cur_addr = 16'd3;
      @(negedge clk_a);
      start = 1'b1; start_addr = 16'd3;
      @(negedge clk_a);
      start = 1'b0;
      chk(busy === 1'b1, "R9 busy after start", 32'(busy), 1);
      repeat (5) @(negedge clk_a);
      start = 1'b1; start_addr = 16'd9;
      @(negedge clk_a);
      start = 1'b0; start_addr = '0;
      while (busy && n < 3000) begin
         if (done) begin
            dones++;
            chk(rd_data === exp_word(16'd3), "R9 in-flight result kept", 32'(rd_data), 32'(exp_word(16'd3)));
         end
         @(negedge clk_a);
         n++;
      end
      chk(dones == 1, "R9 single completion", 32'(dones), 1);
      repeat (20) @(negedge clk_a);
      chk(!read_req && !busy, "R9 ignored start issued nothing", {30'd0, read_req, busy}, 0);
   endtask

   task automatic t_idle_bus();
      chk(bus_data === '0, "R10 idle bus zero", 32'(bus_data), 0);
      chk(!req_drive_en && !rsp_drive_en, "R10 idle no driver", {30'd0, req_drive_en, rsp_drive_en}, 0);
   endtask

   task automatic t_order();
      chk(bad_r2 == 0, "R2 request edges", 32'(bad_r2), 0);
      chk(bad_r3 == 0, "R3 acknowledge edges", 32'(bad_r3), 0);
      chk(bad_r4 == 0, "R4 data-ready rise and latency", 32'(bad_r4), 0);
      chk(bad_r5 == 0, "R5 closing edges", 32'(bad_r5), 0);
      chk(bad_r6 == 0, "R6 exclusive drive", 32'(bad_r6), 0);
   endtask

   initial begin
      t_reset();
      t_idle_bus();
      t_basic();
      t_idle_bus();
      t_wrap();
      t_busy();
      do_read(16'd7, "post-busy a7");
      t_idle_bus();
      t_order();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule